// File: doc/BRIEF.md
# Power-State Reset and PLL Strap Generator

This block watches a raw main-power-good input and produces two things for a processor. The first is a reset pulse. One is issued when the board first powers up. Another is issued each time the power state changes, whether power is lost or restored. The second is a pair of clock-mode strap outputs that tell the processor's PLL how to run. Both straps go high, selecting 2x multiply, while power is good. Both go low, selecting PLL bypass, while it is not. Bypass must be in force whenever the processor clock may be swapped on the fly between slow sources.

The raw input is first brought into the clock domain by a synchronizer chain. It then passes a level filter that accepts a new level only after that level has been seen on a set number of consecutive clock samples. A short glitch therefore cannot cause a burst of resets. A change in the accepted level loads a pulse counter, and the reset output stays asserted while the counter is non-zero. The straps take the new encoding on the same clock edge that loads the counter, and they do not move again until the next accepted change. A change that arrives while a pulse is already running reloads the counter to its full length.

Top module: `pwr_strap_reset`

## Requirements
- R1: While `por_n` is low, `reset_out` is 1 and both `clksel1` and `clksel2` are 0, without waiting for a clock edge.
- R2: After `por_n` is released, and with no power change, `reset_out` falls on the PULSE_LEN-th rising clock edge (default 16).
- R3: Each accepted change of the power level, rising or falling, holds `reset_out` high for exactly PULSE_LEN clock cycles.
- R4: For an input change that is accepted, `reset_out` rises on the (SYNC_STAGES + FILT_LEN + 1)-th rising edge after the change. With the defaults 2 and 4 this is the 7th edge.
- R5: A `pg_raw` level held for fewer than FILT_LEN consecutive clock samples is ignored. It produces no reset and leaves the straps unchanged.
- R6: A `pg_raw` level held for exactly FILT_LEN consecutive samples is accepted.
- R7: The strap encoding is as follows. With power good accepted, `clksel1`=`clksel2`=1 (2x mode). With power not good, both are 0 (bypass). The level accepted before any change after `por_n` is "not good".
- R8: The straps take their new value on the same edge on which `reset_out` rises. They change only on an accepted change, so they stay stable for the whole pulse.
- R9: An accepted change that occurs while `reset_out` is already high reloads the full PULSE_LEN count, counted from that change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| pg_raw | input | 1 | Unconditioned main-power-good level (1 = good) |
| reset_out | output | 1 | Active-high processor reset pulse |
| clksel1 | output | 1 | PLL mode strap, bit 1 |
| clksel2 | output | 1 | PLL mode strap, bit 2 |

## Verification
The hardest case to reach is a second accepted change landing in the middle of a pulse that is still running. Another hard case is a level that lasts exactly as long as the filter window, where being one sample short or long flips the outcome.

The stimulus reaches the first case by waiting at the ports for `reset_out` to rise, then counting a few cycles before driving the opposite level. The stimulus reaches the second by holding a level for exactly FILT_LEN cycles and then reverting it. Holding the level for FILT_LEN minus one cycles gives the rejected counterpart. The total high time of the merged pulse shows whether the counter was reloaded.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

    typedef logic [1:0] strap_t;

    localparam strap_t STRAP_BYPASS = 2'b00;
    localparam strap_t STRAP_X2     = 2'b11;

    function automatic strap_t strap_for(input logic power_ok);
        return power_ok ? STRAP_X2 : STRAP_BYPASS;
    endfunction

endpackage

// File: rtl/pgs_sync.sv
module pgs_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [SYNC_STAGES-1:0] chain_d, chain_q;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_chain
            always_comb chain_d = {chain_q[SYNC_STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[SYNC_STAGES-1];

endmodule

// File: rtl/pgs_filter.sv
module pgs_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level_o
);

    localparam int CW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

    typedef struct packed {
        logic          level;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t q, d;

    always_comb begin
        d = q;
        if (din != q.level) begin
            if (q.cnt == LAST) begin
                d.level = din;
                d.cnt   = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{level: 1'b0, cnt: '0};
        else        q <= d;
    end

    assign level_o = q.level;

    // R5: the accepted level moves only once the run counter has filled
    a_r5_no_early_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (q.level != $past(q.level)) |-> ($past(q.cnt) == LAST));

endmodule

// File: rtl/pgs_pulse.sv
module pgs_pulse
    import pgs_pkg::*;
#(
    parameter int PULSE_LEN = 16
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   level_i,
    output logic   rst_pulse_o,
    output strap_t strap_o
);

    localparam int PW = $clog2(PULSE_LEN + 1);
    localparam logic [PW-1:0] FULL = PW'(PULSE_LEN);

    typedef struct packed {
        logic          prev;
        strap_t        strap;
        logic [PW-1:0] cnt;
    } pls_t;

    pls_t q, d;
    logic pg_edge;

    always_comb begin
        d       = q;
        pg_edge = level_i ^ q.prev;
        d.prev  = level_i;
        if (pg_edge) begin
            d.cnt   = FULL;
            d.strap = strap_for(level_i);
        end else if (q.cnt != '0) begin
            d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{prev: 1'b0, strap: STRAP_BYPASS, cnt: FULL};
        else        q <= d;
    end

    assign rst_pulse_o = (q.cnt != '0);
    assign strap_o     = q.strap;

    // R9: any accepted change, even mid-pulse, reloads the full count
    a_r9_reload_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        pg_edge |=> (q.cnt == FULL));

    // R3: a running pulse shortens by exactly one per cycle
    a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!pg_edge && q.cnt != '0) |=> (q.cnt == $past(q.cnt) - 1'b1));

    // R8: straps hold unless an accepted change occurs
    a_r8_strap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_edge |=> $stable(q.strap));

endmodule

// File: rtl/pwr_strap_reset.sv
module pwr_strap_reset
    import pgs_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4,
    parameter int PULSE_LEN   = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic pg_raw,
    output logic reset_out,
    output logic clksel1,
    output logic clksel2
);

    logic   pg_sync;
    logic   pg_filt;
    strap_t strap;

    pgs_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (por_n),
        .din   (pg_raw),
        .dout  (pg_sync)
    );

    pgs_filter #(.FILT_LEN(FILT_LEN)) u_filter (
        .clk     (clk),
        .rst_n   (por_n),
        .din     (pg_sync),
        .level_o (pg_filt)
    );

    pgs_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk         (clk),
        .rst_n       (por_n),
        .level_i     (pg_filt),
        .rst_pulse_o (reset_out),
        .strap_o     (strap)
    );

    assign clksel1 = strap[1];
    assign clksel2 = strap[0];

    // R1: reset state seen at every clock edge while power-on reset is held
    always @(posedge clk) begin
        if (!por_n) begin
            a_r1_por_state: assert (reset_out && !clksel1 && !clksel2);
        end
    end

    // R7: outside a pulse, with a settled level, straps encode that level
    a_r7_strap_matches_level: assert property (@(posedge clk) disable iff (!por_n)
        (!reset_out && $stable(pg_filt)) |-> (clksel1 == pg_filt && clksel2 == pg_filt));

endmodule

// File: tb/pwr_strap_reset_tb.sv
module pwr_strap_reset_tb;

    localparam int CLK_PERIOD = 10;
    localparam int PULSE_LEN  = 16;

    typedef struct packed {
        logic lvl;
        int   hold;
        int   exp_hi;
        logic exp_strap;
    } vec_t;

    // walk: drive lvl, sample hold cycles, count reset_out highs, check straps at end
    localparam vec_t VEC [0:7] = '{
        '{1'b1, 40, 16, 1'b1},   // R3 rise, R7 2x
        '{1'b1, 40,  0, 1'b1},   // no change
        '{1'b0, 40, 16, 1'b0},   // R3 fall, R7 bypass
        '{1'b1,  3,  0, 1'b0},   // R5 glitch of FILT_LEN-1
        '{1'b0, 40,  0, 1'b0},   // R5 no reset from glitch
        '{1'b1,  4,  0, 1'b0},   // R6 exactly FILT_LEN
        '{1'b0, 40, 20, 1'b0},   // R6 accepted + R9 merged pulse
        '{1'b1, 40, 16, 1'b1}
    };

    logic clk = 1'b0;
    logic por_n = 1'b1;
    logic pg_raw = 1'b0;
    logic reset_out, clksel1, clksel2;

    int n_checks = 0;
    int n_fail   = 0;

    pwr_strap_reset u_dut (
        .clk       (clk),
        .por_n     (por_n),
        .pg_raw    (pg_raw),
        .reset_out (reset_out),
        .clksel1   (clksel1),
        .clksel2   (clksel2)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic count_high(input int cycles, output int hi);
        hi = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (reset_out) hi++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int hi;
        int first;
        #1 por_n = 1'b0;

        // R1 reset state
        repeat (4) @(negedge clk);
        check(reset_out == 1'b1, "R1 reset_out", reset_out, 1);
        check({clksel1, clksel2} == 2'b00, "R1 straps", {clksel1, clksel2}, 0);

        // R2 power-up pulse length
        por_n = 1'b1;
        count_high(40, hi);
        check(hi == PULSE_LEN - 1, "R2 power-up length", hi, PULSE_LEN - 1);

        // table walk
        for (int v = 0; v < 8; v++) begin
            pg_raw = VEC[v].lvl;
            count_high(VEC[v].hold, hi);
            check(hi == VEC[v].exp_hi, $sformatf("R3/R5/R6 vec%0d pulse", v), hi, VEC[v].exp_hi);
            check(clksel1 == VEC[v].exp_strap && clksel2 == VEC[v].exp_strap,
                  $sformatf("R7 vec%0d strap", v), {clksel1, clksel2}, {2{VEC[v].exp_strap}});
        end

        // R9 restart: change again 3 cycles after pulse start
        pg_raw = 1'b0;
        hi = 0;
        for (int i = 0; i < 30 && !reset_out; i++) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            if (reset_out) hi++;
            @(negedge clk);
        end
        if (reset_out) hi++;
        pg_raw = 1'b1;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (reset_out) hi++;
        end
        check(hi == 26, "R9 restarted pulse", hi, 26);
        check({clksel1, clksel2} == 2'b11, "R7 strap after restart", {clksel1, clksel2}, 3);

        // R4 latency and R8 strap at rise
        pg_raw = 1'b0;
        first = 0;
        for (int i = 1; i <= 20 && first == 0; i++) begin
            @(negedge clk);
            if (reset_out) begin
                first = i;
                check({clksel1, clksel2} == 2'b00, "R8 strap at reset rise", {clksel1, clksel2}, 0);
            end
        end
        check(first == 7, "R4 latency", first, 7);
        count_high(40, hi);
        check(hi == PULSE_LEN - 1, "R3 remaining pulse", hi, PULSE_LEN - 1);

        // R1 asynchronous reset mid-run, after power good restored
        pg_raw = 1'b1;
        repeat (40) @(negedge clk);
        check({clksel1, clksel2} == 2'b11, "R7 good before por", {clksel1, clksel2}, 3);
        por_n = 1'b0;
        #1;
        check(reset_out == 1'b1, "R1 async reset_out", reset_out, 1);
        check({clksel1, clksel2} == 2'b00, "R1 async straps", {clksel1, clksel2}, 0);
        pg_raw = 1'b0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        count_high(40, hi);
        check(hi == PULSE_LEN - 1, "R2 re-power-up length", hi, PULSE_LEN - 1);

        finish_run();
    end

endmodule